// File: doc/BRIEF.md
# Dual Signed Halfword Multiply-Accumulate Long Unit

This execution datapath takes two 32-bit operands, N and M, and splits each into a bottom and a top signed halfword. It forms two signed 16x16 products and adds both to a 64-bit accumulator value. The accumulator arrives as separate low and high 32-bit words, and the result leaves the same way. An exchange control swaps the two halfwords of M before the multiplications. This gives cross products (bottom x top and top x bottom) in place of the straight pairing.

The products themselves cannot overflow. Each product is sign-extended to the full accumulator width before the addition. Any overflow of the 64-bit addition wraps silently modulo 2^64, and no flag reports it. Operands are accepted on an input valid strobe. The result appears with an output valid after a fixed latency of one or two cycles, chosen by a parameter (default two). A new operation can be accepted every cycle.

Top module: `dual_mac64`

## Requirements
- R1: With swap_m = 0, the result is acc + sN[15:0]*sM[15:0] + sN[31:16]*sM[31:16]. Here acc = {acc_hi, acc_lo}, and "s" means the halfword is taken as a signed two's-complement value.
- R2: With swap_m = 1, the halfwords of M are exchanged first, so the result is acc + sN[15:0]*sM[31:16] + sN[31:16]*sM[15:0].
- R3: Every product is signed and exact. With all four halfwords at 0x8000, each product is +2^30, and the sum of both products (+2^31) is added as a positive 64-bit quantity. It is not treated as a 32-bit overflow.
- R4: The 64-bit sum wraps modulo 2^64 with no indication. For example, 0x7FFFFFFF_FFFFFFFF plus a positive sum of products gives a negative 64-bit value.
- R5: The accumulator is taken as acc_hi (bits 63:32) and acc_lo (bits 31:0), and the result is returned the same way. A carry or borrow out of the low word propagates into the high word.
- R6: out_valid is high exactly LATENCY cycles after each cycle in which in_valid is sampled high (LATENCY is 1 or 2; default 2).
- R7: out_valid is low in every cycle that does not correspond to an accepted input.
- R8: A synchronous active-high rst forces out_valid low at the next clock edge and discards operations in flight.
- R9: Inputs presented on consecutive cycles each produce their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this cycle are accepted |
| src_n | input | 32 | First operand, two signed halfwords |
| src_m | input | 32 | Second operand, two signed halfwords |
| swap_m | input | 1 | Exchange the halfwords of src_m before multiplying |
| acc_lo | input | 32 | Accumulator bits 31:0 |
| acc_hi | input | 32 | Accumulator bits 63:32 |
| out_valid | output | 1 | Result words are valid |
| res_lo | output | 32 | Result bits 31:0 |
| res_hi | output | 32 | Result bits 63:32 |

## Verification
The block holds no long-lived state, so a fault shows at the ports within LATENCY cycles of the first operand that exercises it:
- A wrong halfword pairing appears as a wrong result on the first operation with distinct top and bottom halves.
- A missing sign extension appears on the first negative product.
- A broken carry chain appears when acc_lo is all ones.

A corrupted valid pipeline stage appears as a valid pulse that is shifted, missing or extra relative to the input strobe. The sweep combines corner halfword values, both swap settings, idle bubbles and accumulators near the wrap points. This covers every one of these paths within a few thousand cycles.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   // supported result latencies of the accumulate pipeline
   localparam int unsigned DMAC_LAT_MIN = 1;
   localparam int unsigned DMAC_LAT_MAX = 2;
   // number of parallel halfword lanes
   localparam int unsigned DMAC_LANES   = 2;

   typedef enum logic {
      LANE_BOTTOM = 1'b0,
      LANE_TOP    = 1'b1
   } dmac_lane_e;
endpackage

// File: rtl/dmac_steer.sv
// Routes the second operand to the lane multipliers, optionally exchanging
// its halfwords so that each lane sees the opposite half.
module dmac_steer #(
   parameter int unsigned HALF_W = 16
) (
   input  logic [2*HALF_W-1:0] m_in,
   input  logic                swap,
   output logic [2*HALF_W-1:0] m_out
);
   localparam int unsigned WORD_W = 2 * HALF_W;

   always_comb begin
      if (swap) begin
         m_out = {m_in[HALF_W-1:0], m_in[WORD_W-1:HALF_W]};
      end else begin
         m_out = m_in;
      end
   end
endmodule

// File: rtl/dmac_lane_mul.sv
// One signed halfword multiplier lane. The product width is twice the
// operand width, so the product is always exact (including -2^(H-1) squared).
module dmac_lane_mul #(
   parameter int unsigned HALF_W = 16
) (
   input  logic        [HALF_W-1:0]   a,
   input  logic        [HALF_W-1:0]   b,
   output logic signed [2*HALF_W-1:0] prod
);
   localparam int unsigned PROD_W = 2 * HALF_W;

   logic signed [PROD_W-1:0] a_x;
   logic signed [PROD_W-1:0] b_x;

   always_comb begin
      a_x  = {{HALF_W{a[HALF_W-1]}}, a};
      b_x  = {{HALF_W{b[HALF_W-1]}}, b};
      prod = a_x * b_x;
   end
endmodule

// File: rtl/dmac_acc_add.sv
// Three-input accumulate adder: both lane products are sign-extended to the
// accumulator width, then summed with it. Overflow wraps at the full width.
module dmac_acc_add #(
   parameter int unsigned HALF_W = 16
) (
   input  logic signed [2*HALF_W-1:0] p_bot,
   input  logic signed [2*HALF_W-1:0] p_top,
   input  logic        [4*HALF_W-1:0] acc,
   output logic        [4*HALF_W-1:0] sum
);
   localparam int unsigned PROD_W = 2 * HALF_W;
   localparam int unsigned ACC_W  = 4 * HALF_W;
   localparam int unsigned EXT_W  = ACC_W - PROD_W;

   logic [ACC_W-1:0] ext_bot;
   logic [ACC_W-1:0] ext_top;

   always_comb begin
      ext_bot = {{EXT_W{p_bot[PROD_W-1]}}, p_bot};
      ext_top = {{EXT_W{p_top[PROD_W-1]}}, p_top};
      sum     = acc + ext_bot + ext_top;
   end
endmodule

// File: rtl/dual_mac64.sv
// Dual signed halfword multiply with long accumulate. LATENCY selects
// a single registered stage (products and add in one cycle) or a split
// where the products are registered before the wide add.
module dual_mac64
   import dmac_pkg::*;
#(
   parameter int unsigned HALF_W  = 16,
   parameter int unsigned LATENCY = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [2*HALF_W-1:0] src_n,
   input  logic [2*HALF_W-1:0] src_m,
   input  logic                swap_m,
   input  logic [2*HALF_W-1:0] acc_lo,
   input  logic [2*HALF_W-1:0] acc_hi,
   output logic                out_valid,
   output logic [2*HALF_W-1:0] res_lo,
   output logic [2*HALF_W-1:0] res_hi
);
   localparam int unsigned WORD_W = 2 * HALF_W;
   localparam int unsigned PROD_W = 2 * HALF_W;
   localparam int unsigned ACC_W  = 2 * WORD_W;
   localparam int unsigned IDX_B  = int'(LANE_BOTTOM);
   localparam int unsigned IDX_T  = int'(LANE_TOP);

   // elaboration-time parameter checks
   if (HALF_W < 2) begin : g_bad_half
      $error("dual_mac64: HALF_W must be at least 2");
   end
   if ((LATENCY < DMAC_LAT_MIN) || (LATENCY > DMAC_LAT_MAX)) begin : g_bad_lat
      $error("dual_mac64: LATENCY must be 1 or 2");
   end

   logic [WORD_W-1:0]        m_eff;
   logic [ACC_W-1:0]         acc_in;
   logic signed [PROD_W-1:0] lane_prod [DMAC_LANES];
   logic                     valid_q;
   logic [ACC_W-1:0]         res_q;

   assign acc_in = {acc_hi, acc_lo};

   dmac_steer #(.HALF_W(HALF_W)) steer_i (
      .m_in  (src_m),
      .swap  (swap_m),
      .m_out (m_eff)
   );

   for (genvar ln = 0; ln < DMAC_LANES; ln++) begin : g_lane
      dmac_lane_mul #(.HALF_W(HALF_W)) mul_i (
         .a    (src_n[ln*HALF_W +: HALF_W]),
         .b    (m_eff[ln*HALF_W +: HALF_W]),
         .prod (lane_prod[ln])
      );
   end

   if (LATENCY == 1) begin : g_lat1
      logic [ACC_W-1:0] sum_w;

      dmac_acc_add #(.HALF_W(HALF_W)) add_i (
         .p_bot (lane_prod[IDX_B]),
         .p_top (lane_prod[IDX_T]),
         .acc   (acc_in),
         .sum   (sum_w)
      );

      always_ff @(posedge clk) begin
         if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
         end else begin
            valid_q <= in_valid;
            if (in_valid) begin
               res_q <= sum_w;
            end
         end
      end
   end else begin : g_lat2
      logic                     s1_valid;
      logic signed [PROD_W-1:0] s1_bot;
      logic signed [PROD_W-1:0] s1_top;
      logic [ACC_W-1:0]         s1_acc;
      logic [ACC_W-1:0]         sum_w;

      // stage 1: capture lane products and the accumulator
      always_ff @(posedge clk) begin
         if (rst) begin
            s1_valid <= 1'b0;
            s1_bot   <= '0;
            s1_top   <= '0;
            s1_acc   <= '0;
         end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
               s1_bot <= lane_prod[IDX_B];
               s1_top <= lane_prod[IDX_T];
               s1_acc <= acc_in;
            end
         end
      end

      dmac_acc_add #(.HALF_W(HALF_W)) add_i (
         .p_bot (s1_bot),
         .p_top (s1_top),
         .acc   (s1_acc),
         .sum   (sum_w)
      );

      // stage 2: register the wide sum
      always_ff @(posedge clk) begin
         if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
         end else begin
            valid_q <= s1_valid;
            if (s1_valid) begin
               res_q <= sum_w;
            end
         end
      end
   end

   assign out_valid = valid_q;
   assign res_lo    = res_q[WORD_W-1:0];
   assign res_hi    = res_q[ACC_W-1:WORD_W];
endmodule

// File: rtl/dual_mac64_chk.sv
// Port-level checker for dual_mac64, attached through bind.
module dual_mac64_chk #(
   parameter int unsigned HALF_W  = 16,
   parameter int unsigned LATENCY = 2
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [2*HALF_W-1:0] src_n,
   input logic [2*HALF_W-1:0] src_m,
   input logic                swap_m,
   input logic [2*HALF_W-1:0] acc_lo,
   input logic [2*HALF_W-1:0] acc_hi,
   input logic                out_valid,
   input logic [2*HALF_W-1:0] res_lo,
   input logic [2*HALF_W-1:0] res_hi
);
   localparam int unsigned WORD_W = 2 * HALF_W;
   localparam int unsigned ACC_W  = 2 * WORD_W;

   // reference computed at full accumulator width from the port values
   function automatic logic [ACC_W-1:0] ref_sum(
      input logic [WORD_W-1:0] n,
      input logic [WORD_W-1:0] m,
      input logic              sw,
      input logic [ACC_W-1:0]  acc
   );
      logic signed [ACC_W-1:0] nb, nt, mb, mt;
      nb = ACC_W'($signed(n[HALF_W-1:0]));
      nt = ACC_W'($signed(n[WORD_W-1:HALF_W]));
      mb = ACC_W'($signed(sw ? m[WORD_W-1:HALF_W] : m[HALF_W-1:0]));
      mt = ACC_W'($signed(sw ? m[HALF_W-1:0] : m[WORD_W-1:HALF_W]));
      return acc + nb * mb + nt * mt;
   endfunction

   logic [ACC_W-1:0] exp_now;
   always_comb exp_now = ref_sum(src_n, src_m, swap_m, {acc_hi, acc_lo});

   assert_reset_clears_R8: assert property (@(posedge clk)
      rst |=> !out_valid);

   if (LATENCY == 1) begin : g_a1
      assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
   end else begin : g_a2
      assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> ##1 out_valid);
   end

   assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, LATENCY));

   // covers R1, R2, R3, R4 and R5 through the full-width reference
   assert_result_R1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ({res_hi, res_lo} == $past(exp_now, LATENCY)));
endmodule

bind dual_mac64 dual_mac64_chk #(.HALF_W(HALF_W), .LATENCY(LATENCY)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .src_n     (src_n),
   .src_m     (src_m),
   .swap_m    (swap_m),
   .acc_lo    (acc_lo),
   .acc_hi    (acc_hi),
   .out_valid (out_valid),
   .res_lo    (res_lo),
   .res_hi    (res_hi)
);

// File: tb/dual_mac64_tb_top.sv
module dual_mac64_tb_top;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        swap_m = 1'b0;
   logic [31:0] src_n = '0, src_m = '0, acc_lo = '0, acc_hi = '0;
   logic        out_valid;
   logic [31:0] res_lo, res_hi;

   always #10 clk = ~clk;   // 50 MHz

   dual_mac64 dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .src_n(src_n), .src_m(src_m),
      .swap_m(swap_m), .acc_lo(acc_lo), .acc_hi(acc_hi),
      .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
   );

   typedef struct {
      int          cyc;
      logic [63:0] val;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   bit   finished = 0;

   function automatic longint prod16(logic [15:0] a, logic [15:0] b);
      return longint'($signed(a)) * longint'($signed(b));
   endfunction

   // advance to the next falling edge and check the outputs there
   task automatic step(string vtag);
      bit ev;
      exp_t e;
      @(negedge clk);
      cyc++;
      ev = (q.size() > 0) && (q[0].cyc == cyc);
      checks++;
      if (out_valid !== ev) begin
         errors++;
         $display("FAIL %s: out_valid at cycle %0d actual %b expected %b",
                  vtag, cyc, out_valid, ev);
      end
      if (ev) begin
         e = q.pop_front();
         checks++;
         if ({res_hi, res_lo} !== e.val) begin
            errors++;
            $display("FAIL %s: result actual %h expected %h", e.tag,
                     {res_hi, res_lo}, e.val);
         end
      end
   endtask

   task automatic issue(logic [31:0] n, logic [31:0] m, logic sw, logic [63:0] acc);
      logic [31:0] mm;
      longint      p, a, r;
      exp_t        e;
      step("R6 R7 R9");
      in_valid = 1'b1; src_n = n; src_m = m; swap_m = sw;
      acc_lo = acc[31:0]; acc_hi = acc[63:32];
      mm = sw ? {m[15:0], m[31:16]} : m;
      p  = prod16(n[15:0], mm[15:0]) + prod16(n[31:16], mm[31:16]);
      a  = longint'(acc);
      r  = a + p;
      e.cyc = cyc + LAT;
      e.val = 64'(r);
      e.tag = sw ? "R2" : "R1";
      if (n == 32'h80008000 && m == 32'h80008000) e.tag = {e.tag, " R3"};
      if ((a[63] == p[63]) && (r[63] != a[63])) e.tag = {e.tag, " R4"};
      if (acc[31:0] == 32'hFFFFFFFF) e.tag = {e.tag, " R5"};
      q.push_back(e);
   endtask

   task automatic idle(string vtag);
      step(vtag);
      in_valid = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   logic [15:0] hv [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h5A3C};
   logic [63:0] av [6] = '{64'h0, 64'h7FFFFFFF_FFFFFFF0, 64'h80000000_00000005,
                           64'hFFFFFFFF_FFFFFFFF, 64'h00000000_FFFFFFFF,
                           64'h12345678_9ABCDEF0};

   initial begin
      int k;
      // R8: reset state
      rst = 1'b1;
      repeat (3) idle("R8");
      rst = 1'b0;
      idle("R8");

      // directed corners
      issue(32'h80008000, 32'h80008000, 1'b0, 64'h0);                   // R3
      issue(32'h80008000, 32'h80008000, 1'b1, 64'hFFFFFFFF_80000000);   // R3
      issue(32'h00010001, 32'h00010001, 1'b0, 64'h00000005_FFFFFFFF);   // R5
      issue(32'h00000001, 32'h0000FFFF, 1'b0, 64'h00000001_00000000);   // R5 borrow
      issue(32'h7FFF7FFF, 32'h7FFF7FFF, 1'b0, 64'h7FFFFFFF_FFFFFFFF);   // R4
      issue(32'h00027FFF, 32'h00030005, 1'b1, 64'h0);                   // R2
      repeat (LAT + 1) idle("R7");

      // near-exhaustive sweep of corner halfwords, both swap settings
      k = 0;
      for (int i0 = 0; i0 < 6; i0++)
         for (int i1 = 0; i1 < 6; i1++)
            for (int i2 = 0; i2 < 6; i2++)
               for (int i3 = 0; i3 < 6; i3++)
                  for (int sw = 0; sw < 2; sw++) begin
                     if (k % 11 == 10) idle("R7");
                     issue({hv[i1], hv[i0]}, {hv[i3], hv[i2]}, sw[0], av[k % 6]);
                     k++;
                  end
      repeat (LAT + 2) idle("R7");

      // R8: reset with an operation in flight discards it
      issue(32'h12345678, 32'h9ABCDEF0, 1'b0, 64'h1);
      step("R8");
      in_valid = 1'b0;
      rst = 1'b1;
      q.delete();
      idle("R8");
      rst = 1'b0;
      repeat (LAT + 2) idle("R8 R7");

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule